// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block joins two 36-bit ports, called A and B, and passes data between them in both directions. Each direction has its own storage stage, and three inputs steer it: a latch enable, a capture clock and an output enable. With the latch enable high, the stage is transparent and the far port follows the near port. With the latch enable low, the stage holds its contents. It loads the near port only when its clock falls.

The two output enables have opposite senses. The A-to-B enable is asserted high, and the B-to-A enable is asserted low. Each port is modelled as an input bus, an output bus and a drive flag, so the block stays free of tri-state logic. An outer pad wrapper can turn each output bus into high impedance whenever its drive flag is low. The output buses always show the stored or transparent value. The storage has no reset, so a direction must be loaded before its held value means anything.

Top module: `univ_bus_xcvr`

## Requirements
- R1: The data width is set by the parameter `WIDTH`, which defaults to 36. Both directions use this width.
- R2: While `ab_le` is 1, `b_out` equals `a_in` and follows every change of `a_in` with no clock.
- R3: While `ab_le` is 0, a 1-to-0 transition of `ab_clk` loads the current `a_in`. From then on `b_out` shows that value.
- R4: While `ab_le` is 0, changes of `a_in` have no effect on `b_out`. A 0-to-1 transition of `ab_clk` also has no effect on `b_out`.
- R5: When `ab_le` falls from 1 to 0, `b_out` keeps the last value that passed through transparently. It keeps that value until the next falling edge of `ab_clk`.
- R6: A falling edge of `ab_clk` while `ab_le` is 1 has no further effect. `b_out` keeps following `a_in`.
- R7: `b_drive` is 1 exactly when `ab_oe` is 1 (asserted high). `b_out` keeps its value whatever `ab_oe` is.
- R8: The B-to-A direction behaves in the same way for transparency, capture and holding. It uses `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R9: `a_drive` is 1 exactly when `ba_oe_n` is 0 (asserted low).
- R10: Activity on one direction never changes the output of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | Value sensed on port A |
| b_in | input | WIDTH | Value sensed on port B |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B capture clock, acts on its falling edge |
| ab_oe | input | 1 | A-to-B output enable, asserted high |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A capture clock, acts on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, asserted low |
| b_out | output | WIDTH | Value presented toward port B |
| b_drive | output | 1 | Port B drive flag |
| a_out | output | WIDTH | Value presented toward port A |
| a_drive | output | 1 | Port A drive flag |

## Verification
On every falling edge of each capture clock, the assertions check two things. The first is that a transparent stage shows its input. The second is that a capture made with the latch enable low is still what the output shows at the next falling edge. Some behaviours appear only in the bench's scenarios, because they depend on what happens between clock edges. These are holding across input changes and rising edges, retaining the last transparent value when the latch enable falls, the polarity of each drive flag, and the independence of the two directions.

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr #(
  parameter int WIDTH = 36
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive
);

  logic [WIDTH-1:0] ab_lat, ab_reg;
  logic [WIDTH-1:0] ba_lat, ba_reg;
  logic             ab_from_reg, ba_from_reg;

  // A to B storage: a latch follows while open, a register loads on falling clock
  always_latch begin
    if (ab_le) ab_lat <= a_in;
  end

  always_ff @(negedge ab_clk) begin
    if (!ab_le) ab_reg <= a_in;
  end

  always_ff @(negedge ab_clk or posedge ab_le) begin
    if (ab_le) ab_from_reg <= 1'b0;
    else       ab_from_reg <= 1'b1;
  end

  assign b_out   = ab_le ? a_in : (ab_from_reg ? ab_reg : ab_lat);
  assign b_drive = ab_oe;

  // B to A storage
  always_latch begin
    if (ba_le) ba_lat <= b_in;
  end

  always_ff @(negedge ba_clk) begin
    if (!ba_le) ba_reg <= b_in;
  end

  always_ff @(negedge ba_clk or posedge ba_le) begin
    if (ba_le) ba_from_reg <= 1'b0;
    else       ba_from_reg <= 1'b1;
  end

  assign a_out   = ba_le ? b_in : (ba_from_reg ? ba_reg : ba_lat);
  assign a_drive = !ba_oe_n;

  assert_ab_transparent_R2: assert property (@(negedge ab_clk)
    ab_le |-> (b_out == a_in));

  assert_ab_capture_R3: assert property (@(negedge ab_clk)
    !ab_le |=> (ab_le || b_out == $past(a_in)));

  assert_ba_transparent_R8: assert property (@(negedge ba_clk)
    ba_le |-> (a_out == b_in));

  assert_ba_capture_R8: assert property (@(negedge ba_clk)
    !ba_le |=> (ba_le || a_out == $past(b_in)));

endmodule

// File: tb/univ_bus_xcvr_bench.sv
module univ_bus_xcvr_bench;
  localparam int WIDTH = 36;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic [WIDTH-1:0] a_in, b_in, b_out, a_out;
  logic ab_le, ab_clk, ab_oe, ba_le, ba_clk, ba_oe_n, b_drive, a_drive;
  int checks, errors;
  bit done;

  univ_bus_xcvr #(.WIDTH(WIDTH)) u_univ_bus_xcvr (
    .a_in(a_in), .b_in(b_in), .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive));

  function automatic logic [WIDTH-1:0] pat(input int k);
    logic [31:0] lo;
    lo = 32'(k) * 32'h9E3779B1 + 32'h1357;
    return {4'(k * 5 + 3), lo};
  endfunction

  task automatic chk(input string tag, input logic [WIDTH-1:0] got, input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    #(HALF);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] other;
    checks = 0; errors = 0; done = 0;
    a_in = '0; b_in = '0; ab_le = 1; ba_le = 1; ab_clk = 0; ba_clk = 0;
    ab_oe = 0; ba_oe_n = 1;
    step();
    // Initial state: drive flags off, both directions transparent
    chk("R7 reset drive", {35'd0, b_drive}, 36'd0);
    chk("R9 reset drive", {35'd0, a_drive}, 36'd0);
    chk("R1 width", 36'(WIDTH), 36'd36);

    for (int i = 0; i < 12; i++) begin
      // A to B direction; B to A held steady
      ba_le = 1; b_in = pat(100 + i); step(); ba_le = 0; step();
      other = pat(100 + i);
      ab_le = 1; a_in = pat(i); step();
      chk("R2 transparent", b_out, pat(i));
      ab_clk = 1; step(); ab_clk = 0; step();
      chk("R6 fall while open", b_out, pat(i));
      a_in = pat(i + 1); step();
      chk("R6 still tracking", b_out, pat(i + 1));
      ab_le = 0; step();
      a_in = pat(i + 2); step();
      chk("R5 retain last transparent", b_out, pat(i + 1));
      ab_clk = 1; step();
      chk("R4 rising edge no effect", b_out, pat(i + 1));
      ab_clk = 0; step();
      chk("R3 falling capture", b_out, pat(i + 2));
      a_in = pat(i + 3); step();
      chk("R4 hold vs input", b_out, pat(i + 2));
      ab_oe = i[0]; step();
      chk("R7 drive flag", {35'd0, b_drive}, {35'd0, i[0]});
      chk("R7 value kept", b_out, pat(i + 2));
      chk("R10 other side untouched", a_out, other);

      // B to A direction; A to B held
      other = pat(i + 2);
      ba_le = 1; b_in = pat(50 + i); step();
      chk("R8 transparent", a_out, pat(50 + i));
      ba_clk = 1; step(); ba_clk = 0; step();
      chk("R8 fall while open", a_out, pat(50 + i));
      ba_le = 0; step();
      b_in = pat(51 + i); step();
      chk("R8 retain", a_out, pat(50 + i));
      ba_clk = 1; step();
      chk("R8 rising no effect", a_out, pat(50 + i));
      ba_clk = 0; step();
      chk("R8 capture", a_out, pat(51 + i));
      b_in = pat(52 + i); step();
      chk("R8 hold", a_out, pat(51 + i));
      ba_oe_n = i[1]; step();
      chk("R9 drive flag", {35'd0, a_drive}, {35'd0, !i[1]});
      chk("R10 other side untouched", b_out, other);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule